// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer working registers of a processor core arranged as a ring of overlapping register windows. A procedure always sees 32 logical registers. Eight of them are globals shared by every window. The other 24 come from the window that the current-window pointer selects.

Each window owns 16 physical registers: eight ins and eight locals. Its eight outs are the ins of the neighbouring window one step below it on the ring. A caller therefore hands arguments to a callee without any copying.

A save command moves the pointer down one window and a restore command moves it up one. Both moves wrap around the ring. Before each move the block checks the bit of the target window in a window-invalid mask supplied from outside. If that bit is set, the block refuses the move and raises an overflow or underflow trap request, so that a handler can spill or fill a window. The block has two combinational read ports and one write port, and all three take 5-bit logical register numbers.

Top module: `win_regfile`

## Requirements
- R1: Logical registers 1 to 7 are globals. They map to the same physical registers whatever the pointer value, so a value written in one window reads back unchanged in every other window.
- R2: Logical registers 16 to 23 are locals and are private to each window. A write to a local in one window is not visible in any other window.
- R3: Logical registers 8 to 15 are outs and 24 to 31 are ins. Out k (register 8+k) of window w is the same physical register as in k (register 24+k) of window (w-1) mod NWIN. This holds across the wrap, so the outs of window 0 are the ins of window NWIN-1.
- R4: Logical register 0 always reads as zero on both read ports, and writes to it are discarded.
- R5: cwp_o resets to 0. A save decrements it and a restore increments it, both modulo NWIN. The new value appears after the clock edge that samples the command.
- R6: When save_i is high, restore_i is low, and the mask bit of the window at (cwp_o-1) mod NWIN is set, ovf_o is high in that same cycle and the pointer keeps its value.
- R7: When restore_i is high, save_i is low, and the mask bit of the window at (cwp_o+1) mod NWIN is set, unf_o is high in that same cycle and the pointer keeps its value.
- R8: When save_i and restore_i are both high, the pointer does not move and neither trap output is raised.
- R9: A write lands at the clock edge in the window selected by the pointer value before that edge, including in a cycle that also moves the pointer. A read of the register being written in the same cycle returns the old value.
- R10: After reset, every register reads as zero in every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Move to the window below |
| restore_i | input | 1 | Move to the window above |
| wim_i | input | 32 | Window-invalid mask, bit w for window w |
| cwp_o | output | 5 | Current window pointer |
| ovf_o | output | 1 | Window overflow trap request |
| unf_o | output | 1 | Window underflow trap request |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write register |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Logical read register, port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Logical read register, port B |
| rdata_b_o | output | 32 | Read data, port B |

## Verification
Some properties are checked by assertions on every cycle:
- the pointer stays below NWIN;
- a move goes exactly one step around the ring;
- a trap or a pair of conflicting commands leaves the pointer still, and the two trap requests never coincide;
- register 0 reads zero;
- a written value is present in its physical slot one cycle later.

The overlap itself can only be shown by the bench scenarios. These include outs becoming ins after a save, the wrap between window 0 and the last window, locals that stay private, and globals that stay shared. Reads that return old data during a write, and the interplay of mask patterns with walks around the full ring, are also shown only there. The bench compares every port against a flat behavioural model on every clock.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned NGLOB = 8;
  localparam int unsigned WSPAN = 16;
  localparam int unsigned CWPW  = 5;
  localparam int unsigned RIDXW = 5;

  typedef enum logic [1:0] {
    GRP_GLOB = 2'd0,
    GRP_OUT  = 2'd1,
    GRP_LOC  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;

  function automatic int unsigned phys_count(int unsigned nwin);
    return NGLOB + WSPAN * nwin;
  endfunction
endpackage

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 8
) (
  input  logic [CWPW-1:0]  cwp_i,
  input  logic [RIDXW-1:0] lreg_i,
  output logic [PW-1:0]    phys_o
);
  grp_e        grp;
  int unsigned below;
  int unsigned idx;

  assign grp   = grp_e'(lreg_i[4:3]);
  // outs of window w live in the ins of window w-1 (ring)
  assign below = (cwp_i == '0) ? (NWIN - 1) : (int'(cwp_i) - 1);

  always_comb begin
    unique case (grp)
      GRP_GLOB: idx = int'(lreg_i[2:0]);
      GRP_OUT:  idx = NGLOB + WSPAN * below + int'(lreg_i[2:0]);
      GRP_LOC:  idx = NGLOB + WSPAN * int'(cwp_i) + 8 + int'(lreg_i[2:0]);
      default:  idx = NGLOB + WSPAN * int'(cwp_i) + int'(lreg_i[2:0]);
    endcase
  end

  assign phys_o = PW'(idx);
endmodule

// File: rtl/wrf_ptr.sv
module wrf_ptr
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [31:0]     wim_i,
  output logic [CWPW-1:0] cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CWPW-1:0] cwp_q, tgt_dn, tgt_up, cwp_d;
  logic            do_save, do_rest;

  assign tgt_dn  = (cwp_q == '0) ? CWPW'(NWIN - 1) : cwp_q - 1'b1;
  assign tgt_up  = (cwp_q == CWPW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
  assign do_save = save_i & ~restore_i;
  assign do_rest = restore_i & ~save_i;
  assign ovf_o   = do_save & wim_i[tgt_dn];
  assign unf_o   = do_rest & wim_i[tgt_up];

  always_comb begin
    cwp_d = cwp_q;
    if (do_save && !ovf_o) cwp_d = tgt_dn;
    else if (do_rest && !unf_o) cwp_d = tgt_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cwp_q <= '0;
    else         cwp_q <= cwp_d;
  end

  assign cwp_o = cwp_q;

  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_q) < NWIN);
  a_r5_save_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !ovf_o) |=>
      (cwp_q == (($past(cwp_q) == '0) ? CWPW'(NWIN - 1) : CWPW'($past(cwp_q) - 1'b1))));
  a_r5_rest_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !unf_o) |=>
      (cwp_q == ((int'($past(cwp_q)) == NWIN - 1) ? '0 : CWPW'($past(cwp_q) + 1'b1))));
  a_r6_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_q));
  a_r7_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_q));
  a_r8_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> $stable(cwp_q));
  a_r8_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |-> !(ovf_o || unf_o));
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}));
endmodule

// File: rtl/wrf_store.sv
module wrf_store
  import wrf_pkg::*;
#(
  parameter int unsigned NPHYS = 136,
  parameter int unsigned PW    = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NRD   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   wphys_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [PW-1:0]   rphys_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);
  logic [XLEN-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHYS); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wphys_i] <= wdata_i;
    end
  end

  // reads are combinational: a same-cycle write is seen only after the edge
  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata_o[p] = mem_q[rphys_i[p]];
  end

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(wphys_i)] == $past(wdata_i)));
  a_r9_index_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(wphys_i) < NPHYS));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [31:0]     wim_i,
  output logic [4:0]      cwp_o,
  output logic            ovf_o,
  output logic            unf_o,
  input  logic            we_i,
  input  logic [4:0]      waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [4:0]      raddr_a_i,
  output logic [XLEN-1:0] rdata_a_o,
  input  logic [4:0]      raddr_b_i,
  output logic [XLEN-1:0] rdata_b_o
);
  localparam int unsigned NPHYS = phys_count(NWIN);
  localparam int unsigned PW    = $clog2(NPHYS);
  localparam int unsigned NRD   = 2;

  logic [CWPW-1:0]  cwp;
  logic [RIDXW-1:0] raddr [NRD];
  logic [PW-1:0]    rphys [NRD];
  logic [XLEN-1:0]  rraw  [NRD];
  logic [XLEN-1:0]  rdat  [NRD];
  logic [PW-1:0]    wphys;
  logic             wen;

  wrf_ptr #(.NWIN(NWIN)) u_ptr (
    .clk_i, .rst_ni, .save_i, .restore_i, .wim_i,
    .cwp_o(cwp), .ovf_o, .unf_o
  );

  assign raddr[0] = raddr_a_i;
  assign raddr[1] = raddr_b_i;

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rmap
    wrf_map #(.NWIN(NWIN), .PW(PW)) u_map (
      .cwp_i(cwp), .lreg_i(raddr[p]), .phys_o(rphys[p])
    );
    assign rdat[p] = (raddr[p] == '0) ? '0 : rraw[p];
  end

  wrf_map #(.NWIN(NWIN), .PW(PW)) u_wmap (
    .cwp_i(cwp), .lreg_i(waddr_i), .phys_o(wphys)
  );
  assign wen = we_i & (waddr_i != '0);

  wrf_store #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN), .NRD(NRD)) u_store (
    .clk_i, .rst_ni, .we_i(wen), .wphys_i(wphys), .wdata_i,
    .rphys_i(rphys), .rdata_o(rraw)
  );

  assign cwp_o     = cwp;
  assign rdata_a_o = rdat[0];
  assign rdata_b_o = rdat[1];

  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));
  a_r4_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));
endmodule

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
  localparam int NW = 8;
  localparam int NP = 8 + 16 * NW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save, rest, we;
  logic [31:0] wim, wd;
  logic [4:0] wa, ra, rb, cwp;
  logic ovf, unf;
  logic [31:0] rda, rdb;

  int checks = 0, errors = 0;
  logic [31:0] mdl [NP];
  int mcwp = 0;
  string force_tag = "";

  always #4 clk = ~clk;

  win_regfile #(.NWIN(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .save_i(save), .restore_i(rest), .wim_i(wim),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf), .we_i(we), .waddr_i(wa), .wdata_i(wd),
    .raddr_a_i(ra), .rdata_a_o(rda), .raddr_b_i(rb), .rdata_b_o(rdb)
  );

  function automatic int slot(int w, int r);
    if (r < 8)  return r;
    if (r >= 24) return 8 + 16 * w + (r - 24);
    if (r >= 16) return 16 + 16 * w + (r - 16);
    return 8 + 16 * ((w + NW - 1) % NW) + (r - 8);
  endfunction

  function automatic string tag_of(int r);
    if (force_tag != "") return force_tag;
    if (r == 0) return "R4";
    if (r < 8)  return "R1";
    if (r >= 16 && r < 24) return "R2";
    return "R3";
  endfunction

  function automatic logic [31:0] model_rd(int r);
    return (r == 0) ? 32'd0 : mdl[slot(mcwp, r)];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, compare, then advance model at posedge
  task automatic step(bit iwe, int iwa, logic [31:0] iwd, int ira, int irb,
                      bit isv, bit irs, logic [31:0] iwim);
    int dn, up;
    bit eo, eu;
    we = iwe; wa = 5'(iwa); wd = iwd; ra = 5'(ira); rb = 5'(irb);
    save = isv; rest = irs; wim = iwim;
    #1;
    dn = (mcwp + NW - 1) % NW;
    up = (mcwp + 1) % NW;
    eo = isv && !irs && iwim[dn];
    eu = irs && !isv && iwim[up];
    chk(tag_of(ira), rda, model_rd(ira));
    chk(tag_of(irb), rdb, model_rd(irb));
    chk("R5", 32'(cwp), 32'(mcwp));
    chk((isv && irs) ? "R8" : "R6", 32'(ovf), 32'(eo));
    chk((isv && irs) ? "R8" : "R7", 32'(unf), 32'(eu));
    @(posedge clk);
    if (iwe && iwa != 0) mdl[slot(mcwp, iwa)] = iwd;
    if (isv && !irs && !eo) mcwp = dn;
    else if (irs && !isv && !eu) mcwp = up;
    @(negedge clk);
  endtask

  task automatic idle_rd(int r1, int r2);
    step(0, 0, 0, r1, r2, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) mdl[i] = '0;
    save = 0; rest = 0; we = 0; wa = 0; wd = 0; ra = 0; rb = 0; wim = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: everything zero after reset
    force_tag = "R10";
    for (int r = 0; r < 32; r += 2) idle_rd(r, r + 1);
    chk("R10", 32'(cwp), 0);
    force_tag = "";

    // fill window 0 with distinct data, read back
    for (int r = 0; r < 32; r++) step(1, r, 32'hA000_0000 + r, 0, 0, 0, 0, 0);
    for (int r = 0; r < 32; r += 2) idle_rd(r, r + 1);

    // R4: write to r0 discarded
    step(1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", rda, 32'd0);

    // R9: same-cycle read of register being written returns old value
    force_tag = "R9";
    step(1, 17, 32'h1234_5678, 17, 17, 0, 0, 0);
    idle_rd(17, 3);
    force_tag = "";

    // R3: after save, ins of window NW-1 are the old outs of window 0
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5", 32'(cwp), NW - 1);
    for (int k = 0; k < 8; k++) begin
      idle_rd(24 + k, 1 + (k % 7));
      chk("R3", rda, 32'hA000_0000 + 8 + k);
    end
    // R2: locals of window NW-1 untouched
    idle_rd(16, 23);
    chk("R2", rda, 32'd0);
    // R9: write with a move in the same cycle uses the old window
    step(1, 20, 32'h5555_0000, 0, 0, 0, 1, 0);
    chk("R9", 32'(cwp), 0);
    idle_rd(20, 17);
    chk("R9", rda, 32'hA000_0014);

    // R5: full ring of restores, tagging every window
    for (int i = 0; i < NW; i++) step(1, 18, 32'hC000_0000 + i, 18, 5, 0, 1, 0);
    chk("R5", 32'(cwp), 0);
    for (int i = 0; i < NW; i++) step(0, 0, 0, 18, 9, 1, 0, 0);

    // R6: overflow when target masked
    step(0, 0, 0, 0, 0, 1, 0, 32'h1 << (NW - 1));
    chk("R6", 32'(cwp), 0);
    // R7: underflow when target masked
    step(0, 0, 0, 0, 0, 0, 1, 32'h2);
    chk("R7", 32'(cwp), 0);
    // R8: both commands, masks everywhere
    step(0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    chk("R8", 32'(cwp), 0);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] m;
      m = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, NW - 1)) : 32'h0;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 31), $urandom,
           $urandom_range(0, 31), $urandom_range(0, 31),
           $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0, m);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule